// File: doc/BRIEF.md
# Directory Flush Write-Back Handler

This block sits on the home-directory side of a cache hierarchy. It accepts flush requests that an L2 slice sends for a single line, pushes the supplied line data straight to memory as a write-back, and returns a write-back acknowledgement once memory confirms the write. While a line is being flushed it is busy. Any further request to that line is held at the request port until the memory confirmation returns the line to the unblocked state.

A small table of tracking entries records each flush in flight. An entry holds the line address, the requester that sent the flush, the original (write-through) requester it is acting for, and a data copy of the line. When the request arrives, the directory's own lookup reports whether it already holds the line dirty. If it does, the entry is marked dirty and keeps the directory's copy. Otherwise the entry takes the flush data. Memory acknowledgements carry only an address and are matched to entries by that address. When the table is full, new flushes are back-pressured rather than dropped.

Top module: `flush_dir_wb`

## Requirements
- R1: After reset no line is busy and no entry is in use. `req_ready` is high and `mem_wr_valid`, `tag_rd_en`, `tag_wr_en` and `rsp_valid` are low.
- R2: A flush is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle `mem_wr_valid` is high for exactly one cycle, with `mem_wr_addr` equal to the request address, `mem_wr_data` equal to `req_data`, and `mem_wr_type` equal to 2'b01 (write-back). With no acceptance, `mem_wr_valid` stays low.
- R3: In the cycle after an acceptance, `tag_rd_en` and `tag_wr_en` are both high for one cycle, and `tag_addr` carries the accepted address.
- R4: While a line has a flush in flight, `req_ready` is low whenever `req_addr` names that line.
- R5: While all `NUM_ENT` tracking entries are in use, `req_ready` is low. A request held through that time is accepted once an entry frees, with its data unchanged.
- R6: When `mem_ack_valid` is high and `mem_ack_addr` matches a line in flight, `rsp_valid` is high for one cycle in the next cycle. `rsp_addr` is the line address, `rsp_dest` is the `req_src` of the flush, and `rsp_wt` is its `req_orig`.
- R7: `rsp_data` returns the entry's data copy. That copy is `req_data` when `dir_line_dirty` was low at acceptance, and `dir_line_data` when it was high.
- R8: In the cycle after a matching acknowledgement, the line is unblocked and a new flush to it is accepted.
- R9: An acknowledgement whose address matches no line in flight produces no response and frees no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Flush request present |
| req_ready | output | 1 | Flush request can be taken this cycle |
| req_addr | input | AW | Line address of the flush |
| req_data | input | DW | Full line of flush data |
| req_src | input | IW | Requesting L2 slice, destination of the ack |
| req_orig | input | IW | Original write-through requester |
| dir_line_dirty | input | 1 | Directory lookup: line already held dirty |
| dir_line_data | input | DW | Directory lookup: its copy of the line |
| tag_rd_en | output | 1 | Directory tag array read strobe |
| tag_wr_en | output | 1 | Directory tag array write strobe |
| tag_addr | output | AW | Tag array line address |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_type | output | 2 | Memory request type, 2'b01 write-back |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_ack_valid | input | 1 | Memory write confirmation |
| mem_ack_addr | input | AW | Address of the confirmed write |
| rsp_valid | output | 1 | Write-back acknowledgement out |
| rsp_addr | output | AW | Line address of the acknowledgement |
| rsp_dest | output | IW | Destination requester |
| rsp_wt | output | IW | Write-through requester field |
| rsp_data | output | DW | Tracking entry's data copy |

## Verification
The assertions rely on a few assumptions about the environment. Memory confirms only addresses it was asked to write. A request held against a low `req_ready` keeps its address and data stable. The lookup inputs are valid in the same cycle as the request. The stimulus keeps to these assumptions in two ways. A held request is replayed unchanged until it is accepted. Memory acknowledgements for real lines are drawn only from lines that have been in flight for at least two cycles. Stray acknowledgements are sent only to addresses that the bench's model shows idle, from a small address pool that makes same-line collisions and a full table frequent.

// File: rtl/fdw_pkg.sv
package fdw_pkg;

    localparam logic [1:0] FDW_MEM_IDLE = 2'b00;
    localparam logic [1:0] FDW_MEM_WB   = 2'b01;

    function automatic int unsigned fdw_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fdw_track_table.sv
module fdw_track_table
    import fdw_pkg::*;
#(
    parameter int unsigned NUM_ENT = 4,
    parameter int unsigned AW      = 16,
    parameter int unsigned DW      = 64,
    parameter int unsigned IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_addr,
    input  logic [IW-1:0] alloc_src,
    input  logic [IW-1:0] alloc_orig,
    input  logic [DW-1:0] alloc_data,
    input  logic          alloc_dirty,
    input  logic [DW-1:0] alloc_dir_data,
    input  logic [AW-1:0] look_addr,
    output logic          look_busy,
    output logic          has_free,
    input  logic          free_en,
    input  logic [AW-1:0] free_addr,
    output logic          free_hit,
    output logic [IW-1:0] free_src,
    output logic [IW-1:0] free_orig,
    output logic [DW-1:0] free_data
);

    localparam int unsigned IXW = fdw_idx_w(NUM_ENT);

    typedef struct packed {
        logic [NUM_ENT-1:0]         valid;
        logic [NUM_ENT-1:0]         dirty;
        logic [NUM_ENT-1:0][AW-1:0] addr;
        logic [NUM_ENT-1:0][IW-1:0] src;
        logic [NUM_ENT-1:0][IW-1:0] orig;
        logic [NUM_ENT-1:0][DW-1:0] data;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [NUM_ENT-1:0] look_match;
    logic [NUM_ENT-1:0] free_match;

    // Per-entry address comparators for the request and ack sides
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_match
        assign look_match[g] = tbl_q.valid[g] && (tbl_q.addr[g] == look_addr);
        assign free_match[g] = tbl_q.valid[g] && (tbl_q.addr[g] == free_addr);
    end

    logic [IXW-1:0] alloc_idx;
    logic [IXW-1:0] hit_idx;

    always_comb begin
        alloc_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!tbl_q.valid[i]) alloc_idx = IXW'(i);
        end
        hit_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (free_match[i]) hit_idx = IXW'(i);
        end
    end

    assign look_busy = |look_match;
    assign has_free  = ~&tbl_q.valid;
    assign free_hit  = |free_match;
    assign free_src  = tbl_q.src[hit_idx];
    assign free_orig = tbl_q.orig[hit_idx];
    assign free_data = tbl_q.data[hit_idx];

    always_comb begin
        tbl_d = tbl_q;
        if (free_en && free_hit) begin
            tbl_d.valid[hit_idx] = 1'b0;
            tbl_d.dirty[hit_idx] = 1'b0;
        end
        if (alloc_en) begin
            tbl_d.valid[alloc_idx] = 1'b1;
            tbl_d.addr[alloc_idx]  = alloc_addr;
            tbl_d.src[alloc_idx]   = alloc_src;
            tbl_d.orig[alloc_idx]  = alloc_orig;
            // Entry is pre-marked from the directory's own line state;
            // the flush data replaces the copy only on a clean entry.
            tbl_d.dirty[alloc_idx] = alloc_dirty;
            tbl_d.data[alloc_idx]  = alloc_dir_data;
            if (!tbl_d.dirty[alloc_idx]) begin
                tbl_d.data[alloc_idx] = alloc_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/fdw_ctrl.sv
module fdw_ctrl
    import fdw_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 64,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    input  logic          ack_fire,
    input  logic [AW-1:0] ack_addr,
    input  logic [IW-1:0] ack_src,
    input  logic [IW-1:0] ack_orig,
    input  logic [DW-1:0] ack_data,
    output logic          tag_rd_en,
    output logic          tag_wr_en,
    output logic [AW-1:0] tag_addr,
    output logic          mem_wr_valid,
    output logic [1:0]    mem_wr_type,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic [IW-1:0] rsp_dest,
    output logic [IW-1:0] rsp_wt,
    output logic [DW-1:0] rsp_data
);

    typedef struct packed {
        logic          wr_v;
        logic [1:0]    wr_type;
        logic [AW-1:0] wr_addr;
        logic [DW-1:0] wr_data;
        logic          tag_v;
        logic [AW-1:0] tag_a;
        logic          rsp_v;
        logic [AW-1:0] rsp_a;
        logic [IW-1:0] rsp_dst;
        logic [IW-1:0] rsp_wtr;
        logic [DW-1:0] rsp_dat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.wr_v    = accept;
        ctl_d.tag_v   = accept;
        ctl_d.rsp_v   = ack_fire;
        ctl_d.wr_type = accept ? FDW_MEM_WB : FDW_MEM_IDLE;
        if (accept) begin
            ctl_d.wr_addr = acc_addr;
            ctl_d.wr_data = acc_data;
            ctl_d.tag_a   = acc_addr;
        end
        if (ack_fire) begin
            ctl_d.rsp_a   = ack_addr;
            ctl_d.rsp_dst = ack_src;
            ctl_d.rsp_wtr = ack_orig;
            ctl_d.rsp_dat = ack_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_wr_valid = ctl_q.wr_v;
    assign mem_wr_type  = ctl_q.wr_type;
    assign mem_wr_addr  = ctl_q.wr_addr;
    assign mem_wr_data  = ctl_q.wr_data;
    assign tag_rd_en    = ctl_q.tag_v;
    assign tag_wr_en    = ctl_q.tag_v;
    assign tag_addr     = ctl_q.tag_a;
    assign rsp_valid    = ctl_q.rsp_v;
    assign rsp_addr     = ctl_q.rsp_a;
    assign rsp_dest     = ctl_q.rsp_dst;
    assign rsp_wt       = ctl_q.rsp_wtr;
    assign rsp_data     = ctl_q.rsp_dat;

endmodule

// File: rtl/flush_dir_wb.sv
module flush_dir_wb
    import fdw_pkg::*;
#(
    parameter int unsigned NUM_ENT = 4,
    parameter int unsigned AW      = 16,
    parameter int unsigned DW      = 64,
    parameter int unsigned IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [IW-1:0] req_src,
    input  logic [IW-1:0] req_orig,
    input  logic          dir_line_dirty,
    input  logic [DW-1:0] dir_line_data,
    output logic          tag_rd_en,
    output logic          tag_wr_en,
    output logic [AW-1:0] tag_addr,
    output logic          mem_wr_valid,
    output logic [1:0]    mem_wr_type,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic          mem_ack_valid,
    input  logic [AW-1:0] mem_ack_addr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic [IW-1:0] rsp_dest,
    output logic [IW-1:0] rsp_wt,
    output logic [DW-1:0] rsp_data
);

    logic          line_busy;
    logic          slot_free;
    logic          ack_hit;
    logic          accept;
    logic          ack_fire;
    logic [IW-1:0] hit_src;
    logic [IW-1:0] hit_orig;
    logic [DW-1:0] hit_data;

    // A line in flight or a full table holds the request at the port
    assign req_ready = slot_free && !line_busy;
    assign accept    = req_valid && req_ready;
    assign ack_fire  = mem_ack_valid && ack_hit;

    fdw_track_table #(
        .NUM_ENT (NUM_ENT),
        .AW      (AW),
        .DW      (DW),
        .IW      (IW)
    ) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_en       (accept),
        .alloc_addr     (req_addr),
        .alloc_src      (req_src),
        .alloc_orig     (req_orig),
        .alloc_data     (req_data),
        .alloc_dirty    (dir_line_dirty),
        .alloc_dir_data (dir_line_data),
        .look_addr      (req_addr),
        .look_busy      (line_busy),
        .has_free       (slot_free),
        .free_en        (mem_ack_valid),
        .free_addr      (mem_ack_addr),
        .free_hit       (ack_hit),
        .free_src       (hit_src),
        .free_orig      (hit_orig),
        .free_data      (hit_data)
    );

    fdw_ctrl #(
        .AW (AW),
        .DW (DW),
        .IW (IW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .acc_addr     (req_addr),
        .acc_data     (req_data),
        .ack_fire     (ack_fire),
        .ack_addr     (mem_ack_addr),
        .ack_src      (hit_src),
        .ack_orig     (hit_orig),
        .ack_data     (hit_data),
        .tag_rd_en    (tag_rd_en),
        .tag_wr_en    (tag_wr_en),
        .tag_addr     (tag_addr),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_type  (mem_wr_type),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .rsp_valid    (rsp_valid),
        .rsp_addr     (rsp_addr),
        .rsp_dest     (rsp_dest),
        .rsp_wt       (rsp_wt),
        .rsp_data     (rsp_data)
    );

endmodule

// File: rtl/fdw_checker.sv
module fdw_checker
    import fdw_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_data,
    input logic          tag_rd_en,
    input logic          tag_wr_en,
    input logic [AW-1:0] tag_addr,
    input logic          mem_wr_valid,
    input logic [1:0]    mem_wr_type,
    input logic [AW-1:0] mem_wr_addr,
    input logic [DW-1:0] mem_wr_data,
    input logic          mem_ack_valid,
    input logic [AW-1:0] mem_ack_addr,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_addr
);

    a_r2_write_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_wr_valid && mem_wr_type == FDW_MEM_WB));

    a_r2_write_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_wr_addr == $past(req_addr) && mem_wr_data == $past(req_data)));

    a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !mem_wr_valid);

    a_r3_tag_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (tag_rd_en && tag_wr_en && tag_addr == $past(req_addr)));

    a_r4_line_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !(req_ready && req_addr == mem_wr_addr));

    a_r6_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(mem_ack_valid) && rsp_addr == $past(mem_ack_addr)));

endmodule

bind flush_dir_wb fdw_checker #(
    .AW (AW),
    .DW (DW)
) u_fdw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .tag_rd_en     (tag_rd_en),
    .tag_wr_en     (tag_wr_en),
    .tag_addr      (tag_addr),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_type   (mem_wr_type),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_ack_valid (mem_ack_valid),
    .mem_ack_addr  (mem_ack_addr),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr)
);

// File: tb/flush_dir_wb_tb.sv
module flush_dir_wb_tb;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [IW-1:0] req_src = '0;
    logic [IW-1:0] req_orig = '0;
    logic          dir_line_dirty = 1'b0;
    logic [DW-1:0] dir_line_data = '0;
    logic          tag_rd_en, tag_wr_en;
    logic [AW-1:0] tag_addr;
    logic          mem_wr_valid;
    logic [1:0]    mem_wr_type;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_ack_valid = 1'b0;
    logic [AW-1:0] mem_ack_addr = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic [IW-1:0] rsp_dest, rsp_wt;
    logic [DW-1:0] rsp_data;

    always #10 clk = ~clk;

    flush_dir_wb #(.NUM_ENT(N), .AW(AW), .DW(DW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_src(req_src), .req_orig(req_orig),
        .dir_line_dirty(dir_line_dirty), .dir_line_data(dir_line_data),
        .tag_rd_en(tag_rd_en), .tag_wr_en(tag_wr_en), .tag_addr(tag_addr),
        .mem_wr_valid(mem_wr_valid), .mem_wr_type(mem_wr_type),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_ack_valid(mem_ack_valid), .mem_ack_addr(mem_ack_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_dest(rsp_dest),
        .rsp_wt(rsp_wt), .rsp_data(rsp_data)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Bench model of lines in flight
    bit            mv[N];
    logic [AW-1:0] ma[N];
    logic [IW-1:0] ms[N], mo[N];
    logic [DW-1:0] md[N];
    int            mage[N];

    // Expected registered outputs for the next sample
    bit            e_mw_v = 0;
    logic [AW-1:0] e_mw_a;
    logic [DW-1:0] e_mw_d;
    bit            e_rsp_v = 0;
    string         e_rsp_tag = "R1";
    logic [AW-1:0] e_rsp_a;
    logic [IW-1:0] e_rsp_s, e_rsp_o;
    logic [DW-1:0] e_rsp_d;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int busy_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (mv[i]) c++;
        return c;
    endfunction

    function automatic int find_line(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [DW-1:0] expect_copy(input logic dty,
            input logic [DW-1:0] fd, input logic [DW-1:0] dd);
        return dty ? dd : fd;
    endfunction

    // One clock: called at a falling edge, returns at the next one
    task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [IW-1:0] s, input logic [IW-1:0] o,
                        input logic dty, input logic [DW-1:0] dd,
                        input logic av, input logic [AW-1:0] aa,
                        output bit accepted);
        int k, j;
        bit er;
        string rq;
        // outputs registered by the previous edge
        chk(mem_wr_valid == e_mw_v, "R2", "mem_wr_valid", 64'(mem_wr_valid), 64'(e_mw_v));
        chk((tag_rd_en == e_mw_v) && (tag_wr_en == e_mw_v), "R3", "tag strobes",
            64'({tag_rd_en, tag_wr_en}), 64'({e_mw_v, e_mw_v}));
        if (e_mw_v) begin
            chk(mem_wr_addr == e_mw_a, "R2", "mem_wr_addr", 64'(mem_wr_addr), 64'(e_mw_a));
            chk(mem_wr_data == e_mw_d, "R2", "mem_wr_data", mem_wr_data, e_mw_d);
            chk(mem_wr_type == 2'b01, "R2", "mem_wr_type", 64'(mem_wr_type), 64'd1);
            chk(tag_addr == e_mw_a, "R3", "tag_addr", 64'(tag_addr), 64'(e_mw_a));
        end
        chk(rsp_valid == e_rsp_v, e_rsp_tag, "rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
        if (e_rsp_v) begin
            chk(rsp_addr == e_rsp_a, "R6", "rsp_addr", 64'(rsp_addr), 64'(e_rsp_a));
            chk(rsp_dest == e_rsp_s, "R6", "rsp_dest", 64'(rsp_dest), 64'(e_rsp_s));
            chk(rsp_wt == e_rsp_o, "R6", "rsp_wt", 64'(rsp_wt), 64'(e_rsp_o));
            chk(rsp_data == e_rsp_d, "R7", "rsp_data", rsp_data, e_rsp_d);
        end
        req_valid = v; req_addr = a; req_data = d; req_src = s; req_orig = o;
        dir_line_dirty = dty; dir_line_data = dd;
        mem_ack_valid = av; mem_ack_addr = aa;
        #1;
        k  = find_line(a);
        er = (busy_count() < N) && (k < 0);
        rq = (k >= 0) ? "R4" : ((busy_count() == N) ? "R5" : "R8");
        chk(req_ready == er, rq, "req_ready", 64'(req_ready), 64'(er));
        accepted = v && er;
        k = av ? find_line(aa) : -1;
        e_mw_v = accepted; e_mw_a = a; e_mw_d = d;
        e_rsp_v = (k >= 0);
        e_rsp_tag = (av && k < 0) ? "R9" : "R6";
        if (k >= 0) begin
            e_rsp_a = ma[k]; e_rsp_s = ms[k]; e_rsp_o = mo[k]; e_rsp_d = md[k];
        end
        j = -1;
        for (int i = 0; i < N; i++) if (!mv[i] && j < 0) j = i;
        for (int i = 0; i < N; i++) if (mv[i]) mage[i]++;
        if (k >= 0) mv[k] = 0;
        if (accepted) begin
            mv[j] = 1; ma[j] = a; ms[j] = s; mo[j] = o; mage[j] = 0;
            md[j] = expect_copy(dty, d, dd);
        end
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] pool_addr(input int i);
        return AW'(16'h0100 + i * 16'h0040);
    endfunction

    function automatic logic [DW-1:0] rnd_data();
        return {$urandom, $urandom};
    endfunction

    task automatic idle_ack(input logic [AW-1:0] aa);
        bit acc;
        step(0, '0, '0, '0, '0, 0, '0, 1, aa, acc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit acc;
        bit p_v;
        logic [AW-1:0] p_a;
        logic [DW-1:0] p_d, p_dd;
        logic [IW-1:0] p_s, p_o;
        logic p_dty;
        void'($urandom(32'd7351));
        for (int i = 0; i < N; i++) begin mv[i] = 0; mage[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(!mem_wr_valid && !rsp_valid && !tag_rd_en && !tag_wr_en, "R1", "outputs idle",
            64'({mem_wr_valid, rsp_valid, tag_rd_en, tag_wr_en}), 64'd0);

        // R5: fill every entry, the last with a dirty directory line (R7)
        for (int i = 0; i < N; i++)
            step(1, pool_addr(i), 64'hA000 + 64'(i), IW'(i), IW'(i + 8), (i == N - 1),
                 64'hD1D1_0000 + 64'(i), 0, '0, acc);
        step(1, pool_addr(4), 64'h5555, 4'h3, 4'h9, 0, '0, 0, '0, acc);
        step(1, pool_addr(4), 64'h5555, 4'h3, 4'h9, 0, '0, 0, '0, acc);
        // free one line while the held request waits, then it goes in
        step(1, pool_addr(4), 64'h5555, 4'h3, 4'h9, 0, '0, 1, pool_addr(N - 1), acc);
        step(1, pool_addr(4), 64'h5555, 4'h3, 4'h9, 0, '0, 0, '0, acc);
        chk(acc == 1'b1, "R5", "held request accepted", 64'(acc), 64'd1);
        // R4: same line busy; R9: stray ack
        step(1, pool_addr(0), 64'h7777, 4'h1, 4'h2, 0, '0, 1, pool_addr(7), acc);
        step(1, pool_addr(0), 64'h7777, 4'h1, 4'h2, 0, '0, 1, pool_addr(0), acc);
        // R8: line unblocked right after its ack
        step(1, pool_addr(0), 64'h7777, 4'h1, 4'h2, 0, '0, 0, '0, acc);
        chk(acc == 1'b1, "R8", "reflush accepted", 64'(acc), 64'd1);
        for (int i = 0; i < N; i++) if (mv[i]) idle_ack(ma[i]);
        idle_ack('0);

        // Random phase
        p_v = 0; p_a = '0; p_d = '0; p_dd = '0; p_s = '0; p_o = '0; p_dty = 0;
        for (int c = 0; c < 4000; c++) begin
            logic av;
            logic [AW-1:0] aa;
            if (!p_v && ($urandom % 10) < 7) begin
                p_v = 1; p_a = pool_addr(int'($urandom % 6)); p_d = rnd_data();
                p_s = IW'($urandom); p_o = IW'($urandom);
                p_dty = ($urandom % 4) == 0; p_dd = rnd_data();
            end
            av = 0; aa = '0;
            if (($urandom % 10) < 4) begin
                int pick = int'($urandom % N);
                if (mv[pick] && mage[pick] >= 2) begin av = 1; aa = ma[pick]; end
            end else if (($urandom % 10) == 0) begin
                aa = pool_addr(int'($urandom % 8));
                if (find_line(aa) < 0) av = 1;
            end
            step(p_v, p_a, p_d, p_s, p_o, p_dty, p_dd, av, aa, acc);
            if (acc) p_v = 0;
        end
        for (int i = 0; i < N; i++) if (mv[i]) idle_ack(ma[i]);
        idle_ack('0);
        idle_ack('0);
        finish_run();
    end

endmodule